// File: doc/BRIEF.md
# Tamper Event Response Controller

This block watches two tamper-sense inputs and, when one of them trips, carries out the response that software has configured for that channel. Three actions are available. The first wipes the 128-byte on-chip user RAM to zeros, one byte per clock. The second drives an external-clear output high for a programmable number of slow time-base ticks, which can cut power to an off-chip SRAM. The third raises a reset request that covers the external-clear window.

Each channel has a sticky tamper flag. While a channel's flag is set, further trips on that channel are ignored. If the channel wiped the RAM, the RAM-select gate stays low until software writes the flag back to zero. Each channel can sense normally-open or normally-closed contacts. It can check its input on every clock or only on cycles that carry the 1 Hz tick.

Top module: `tamper_resp`

## Requirements
- R1: After reset, tamperFlag is 0, ramSel is 1, and ramWe, wipeBusy, wipeDone, extClr and rstReq are all 0.
- R2: A channel's configuration is written with cfgWe at cfgAddr 0 (channel 0) or 1 (channel 1). The cfgData bits are: bit0 arm, bit1 internal wipe, bit2 external clear, bit3 open mode, bit4 pull strength, bit5 sampled, bits 7:6 pulse code. A channel trips when it is armed and its tamperIn equals its open-mode bit. That means a high input trips an open-mode channel and a low input trips a closed-mode channel. The flag appears in tamperFlag after the clock edge that sees the trip. An unarmed channel never trips.
- R3: A channel with the sampled bit set trips only on a cycle where tick1Hz is 1. A channel without it trips on any cycle.
- R4: A trip on a channel with internal wipe enabled starts the wipe at the next edge. For 128 consecutive cycles, ramWe and wipeBusy are 1, ramAddr runs 0 to 127, and ramWdata is 0. After that, wipeDone is 1 and ramWe is 0.
- R5: ramSel is 0 from the trip edge of a channel with internal wipe enabled until that channel's flag is cleared. A trip without internal wipe leaves ramSel at 1.
- R6: A trip on a channel with external clear enabled sets extClr at the trip edge. extClr falls at the edge of the Nth later baseTick, where N is 1, 2, 4 or 8 for pulse codes 0, 1, 2 or 3.
- R7: rstReq is 1 whenever extClr is 1 and stays 1 until one further baseTick after extClr falls. It is never raised by a trip without external clear.
- R8: A write to cfgAddr 2 clears each flag whose cfgData bit (bit0 for channel 0, bit1 for channel 1) is 0 and keeps each flag whose bit is 1. A set flag is sticky, and a repeated tamper on its channel starts no new wipe or pulse.
- R9: The pull-strength bit has no effect on detection or on any response.
- R10: If both channels trip in the same cycle, channel 0's pulse code sets the width. A trip while a pulse is running, or while a wipe is running, does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | 0/1 channel config, 2 flag register |
| cfgData | input | 8 | Write data |
| tamperIn | input | 2 | Synchronised tamper-sense levels, one per channel |
| tick1Hz | input | 1 | One-cycle strobe once per second |
| baseTick | input | 1 | Slow time-base strobe for the external-clear width |
| ramWe | output | 1 | Wipe write enable to user RAM |
| ramAddr | output | 7 | Wipe address |
| ramWdata | output | 8 | Wipe data, always zero |
| ramSel | output | 1 | User RAM select gate, low blocks reads |
| wipeBusy | output | 1 | Wipe running, other RAM accesses stall |
| wipeDone | output | 1 | Last wipe finished |
| extClr | output | 1 | External SRAM clear drive |
| rstReq | output | 1 | System reset request |
| tamperFlag | output | 2 | Sticky tamper flags |

## Verification
Every response is registered once, so the flag, the first wipe write, extClr and rstReq all become visible right after the edge that saw the trip. The bench drives inputs 2 ns after a rising edge and checks outputs after the next edge, with no extra wait. The wipe is followed cycle by cycle, with address i expected i+1 edges after the trip. extClr is checked after each individual baseTick, and it must stay steady on the plain cycles between ticks. Detection is swept over every channel, mode, pull-strength and sampling combination, with expected trip levels computed from the mode bit.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int PW_W = 2;

  // configuration byte field positions
  localparam int BIT_ARM      = 0;
  localparam int BIT_WIPE_INT = 1;
  localparam int BIT_WIPE_EXT = 2;
  localparam int BIT_OPEN     = 3;
  localparam int BIT_PULL     = 4;
  localparam int BIT_SAMPLED  = 5;
  localparam int BIT_PW_LO    = 6;

  typedef struct packed {
    logic [PW_W-1:0] width;
    logic            sampled;
    logic            openMode;
    logic            wipeExt;
    logic            wipeInt;
    logic            arm;
  } chanCfg_t;

  typedef struct packed {
    logic            startWipe;
    logic            startPulse;
    logic [PW_W-1:0] widthCode;
  } respStrobe_t;
endpackage

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CFG_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [NUM_CH-1:0] tamperIn,
  input  logic              tick1Hz,
  input  logic              wipeBusy,
  input  logic              pulseActive,
  output respStrobe_t       strobe,
  output logic [NUM_CH-1:0] flag,
  output logic              ramSel
);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CH);

  chanCfg_t          cfg [NUM_CH];
  logic [NUM_CH-1:0] flagQ, wipedQ, trip, intMask, extMask, keep;
  logic              flagWr;
  logic              unusedPull;

  assign unusedPull = cfgData[BIT_PULL];
  assign flagWr     = cfgWe && (cfgAddr == FLAG_ADDR);
  assign keep       = flagWr ? cfgData[NUM_CH-1:0] : '1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg[i] <= '0;
      end else if (cfgWe && cfgAddr == ADDR_W'(i)) begin
        cfg[i].arm      <= cfgData[BIT_ARM];
        cfg[i].wipeInt  <= cfgData[BIT_WIPE_INT];
        cfg[i].wipeExt  <= cfgData[BIT_WIPE_EXT];
        cfg[i].openMode <= cfgData[BIT_OPEN];
        cfg[i].sampled  <= cfgData[BIT_SAMPLED];
        cfg[i].width    <= cfgData[BIT_PW_LO +: PW_W];
      end
    end

    assign trip[i] = !flagQ[i] && cfg[i].arm &&
                     (tamperIn[i] == cfg[i].openMode) &&
                     (!cfg[i].sampled || tick1Hz);
    assign intMask[i] = cfg[i].wipeInt;
    assign extMask[i] = cfg[i].wipeExt;

    assert_flag_needs_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(cfg[i].arm));
    assert_sampled_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(flagQ[i]) && $past(cfg[i].sampled)) |-> $past(tick1Hz));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagQ[i]) |-> $past(flagWr));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      wipedQ <= '0;
    end else begin
      flagQ  <= (flagQ & keep) | trip;
      wipedQ <= (wipedQ & keep) | (trip & intMask);
    end
  end

  always_comb begin
    strobe.startWipe  = |(trip & intMask) && !wipeBusy;
    strobe.startPulse = |(trip & extMask) && !pulseActive;
    strobe.widthCode  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (trip[i] && extMask[i]) strobe.widthCode = cfg[i].width;
    end
  end

  assign flag   = flagQ;
  assign ramSel = ~|wipedQ;

  assert_sel_needs_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ramSel |-> |flagQ);
endmodule

// File: rtl/tamper_dp.sv
module tamper_dp
  import tamper_pkg::*;
#(
  parameter int RAM_DEPTH = 128,
  parameter int DATA_W    = 8,
  localparam int RADDR_W  = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  respStrobe_t        strobe,
  input  logic               baseTick,
  output logic               ramWe,
  output logic [RADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0]  ramWdata,
  output logic               wipeBusy,
  output logic               wipeDone,
  output logic               pulseActive,
  output logic               rstReq
);
  localparam int                 CNT_W     = 1 << PW_W;
  localparam logic [RADDR_W-1:0] LAST_ADDR = RADDR_W'(RAM_DEPTH - 1);

  logic [RADDR_W-1:0] addrQ;
  logic               busyQ, doneQ;
  logic [CNT_W-1:0]   cntQ;
  logic               activeQ, holdQ;

  // wipe walker: one zero byte per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (strobe.startWipe) begin
      addrQ <= '0;
      busyQ <= 1'b1;
      doneQ <= 1'b0;
    end else if (busyQ) begin
      if (addrQ == LAST_ADDR) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else begin
        addrQ <= addrQ + 1'b1;
      end
    end
  end

  // external-clear width counter and trailing reset hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      activeQ <= 1'b0;
      holdQ   <= 1'b0;
    end else if (strobe.startPulse) begin
      cntQ    <= CNT_W'(1) << strobe.widthCode;
      activeQ <= 1'b1;
      holdQ   <= 1'b0;
    end else if (activeQ && baseTick) begin
      if (cntQ == CNT_W'(1)) begin
        activeQ <= 1'b0;
        holdQ   <= 1'b1;
      end
      cntQ <= cntQ - 1'b1;
    end else if (holdQ && baseTick) begin
      holdQ <= 1'b0;
    end
  end

  assign ramWe       = busyQ;
  assign ramAddr     = addrQ;
  assign ramWdata    = '0;
  assign wipeBusy    = busyQ;
  assign wipeDone    = doneQ;
  assign pulseActive = activeQ;
  assign rstReq      = activeQ | holdQ;

  assert_wipe_from_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (addrQ == '0));
  assert_wipe_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> (addrQ == $past(addrQ) + 1'b1));
  assert_clr_falls_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeQ) |-> $past(baseTick));
  assert_rst_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReq) |-> ($past(baseTick) && !activeQ));
endmodule

// File: rtl/tamper_resp.sv
module tamper_resp
  import tamper_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int RAM_DEPTH = 128,
  parameter int DATA_W    = 8,
  parameter int CFG_W     = 8,
  localparam int CADDR_W  = $clog2(NUM_CH + 1),
  localparam int RADDR_W  = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [NUM_CH-1:0]  tamperIn,
  input  logic               tick1Hz,
  input  logic               baseTick,
  output logic               ramWe,
  output logic [RADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0]  ramWdata,
  output logic               ramSel,
  output logic               wipeBusy,
  output logic               wipeDone,
  output logic               extClr,
  output logic               rstReq,
  output logic [NUM_CH-1:0]  tamperFlag
);
  respStrobe_t strobe;
  logic        pulseActive;

  tamper_ctrl #(.NUM_CH(NUM_CH), .CFG_W(CFG_W), .ADDR_W(CADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .tamperIn(tamperIn), .tick1Hz(tick1Hz), .wipeBusy(wipeBusy),
    .pulseActive(pulseActive), .strobe(strobe), .flag(tamperFlag), .ramSel(ramSel)
  );

  tamper_dp #(.RAM_DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseTick(baseTick),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata), .wipeBusy(wipeBusy),
    .wipeDone(wipeDone), .pulseActive(pulseActive), .rstReq(rstReq)
  );

  assign extClr = pulseActive;
endmodule

// File: tb/tamper_resp_tb.sv
module tamper_resp_tb_top;
  logic       clk = 1'b0;
  logic       rstN, cfgWe, tick1Hz, baseTick;
  logic [1:0] cfgAddr, tamperIn, tamperFlag;
  logic [7:0] cfgData, ramWdata;
  logic [6:0] ramAddr;
  logic       ramWe, ramSel, wipeBusy, wipeDone, extClr, rstReq;
  int         nChecks = 0;
  int         nFail = 0;

  always #10 clk = ~clk;

  tamper_resp dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .tamperIn(tamperIn), .tick1Hz(tick1Hz), .baseTick(baseTick),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata), .ramSel(ramSel),
    .wipeBusy(wipeBusy), .wipeDone(wipeDone), .extClr(extClr), .rstReq(rstReq),
    .tamperFlag(tamperFlag)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic pulseBase();
    baseTick = 1'b1;
    tick();
    baseTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    tamperIn = 2'b00; tick1Hz = 1'b0; baseTick = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 flag", tamperFlag, 0);
    chk("R1 ramSel", ramSel, 1);
    chk("R1 outputs", {ramWe, wipeBusy, wipeDone, extClr, rstReq}, 0);

    // R2 R3 R9 detection sweep
    for (int ch = 0; ch < 2; ch++) begin
      for (int cfgv = 0; cfgv < 8; cfgv++) begin
        logic openM, pullB, sampB;
        logic [7:0] d;
        openM = cfgv[0]; pullB = cfgv[1]; sampB = cfgv[2];
        d = {2'b00, sampB, pullB, openM, 3'b001};
        tamperIn = {~openM, ~openM};
        wrReg(2'(ch), {d[7:1], 1'b0});
        tamperIn[ch] = openM;
        tick(); tick();
        chk("R2 unarmed no trip", tamperFlag, 0);
        tamperIn[ch] = ~openM;
        wrReg(2'(ch), d);
        tamperIn[ch] = openM;
        if (sampB) begin
          tick(); tick(); tick();
          chk("R3 sampled waits for tick", tamperFlag, 0);
          tick1Hz = 1'b1;
          tick();
          tick1Hz = 1'b0;
        end else begin
          tick();
        end
        chk("R2 R9 trip sets flag", tamperFlag, 1 << ch);
        chk("R9 no response side effects", {ramWe, extClr, rstReq, ~ramSel}, 0);
        tamperIn[ch] = ~openM;
        wrReg(2'd2, 8'h00);
        chk("R8 flag cleared", tamperFlag, 0);
        wrReg(2'(ch), 8'h00);
      end
    end

    // R4 R5 wipe, then R8 repeat ignored
    tamperIn = 2'b00;
    wrReg(2'd0, 8'h0B);
    tamperIn = 2'b01;
    tick();
    for (int i = 0; i < 128; i++) begin
      chk("R4 wipe addr", ramAddr, i);
      chk("R4 wipe we/busy/data", {ramWe, wipeBusy, ramWdata}, {2'b11, 8'h00});
      chk("R5 ramSel low", ramSel, 0);
      if (i == 60) begin
        tamperIn = 2'b00;
      end
      tick();
    end
    chk("R4 wipe finished", {ramWe, wipeBusy, wipeDone}, 3'b001);
    tamperIn = 2'b01;
    tick(); tick();
    chk("R8 repeat tamper no rewipe", {ramWe, wipeDone, tamperFlag}, 4'b0101);
    chk("R5 ramSel held low", ramSel, 0);
    tamperIn = 2'b00;
    wrReg(2'd2, 8'h02);
    chk("R5 ramSel restored", ramSel, 1);
    chk("R8 flag cleared by 0", tamperFlag, 0);
    wrReg(2'd0, 8'h00);

    // R6 R7 pulse width sweep on channel 1
    for (int code = 0; code < 4; code++) begin
      int n;
      n = 1 << code;
      wrReg(2'd1, 8'(code << 6) | 8'h0D);
      tamperIn = 2'b10;
      tick();
      chk("R6 extClr rises at trip", extClr, 1);
      chk("R7 rstReq with extClr", rstReq, 1);
      tamperIn = 2'b00;
      for (int k = 1; k <= n; k++) begin
        pulseBase();
        chk("R6 extClr after base tick", extClr, (k < n) ? 1 : 0);
        chk("R7 rstReq held", rstReq, 1);
        tick();
        chk("R6 extClr steady between ticks", extClr, (k < n) ? 1 : 0);
      end
      chk("R5 ramSel untouched by ext", {ramSel, wipeBusy}, 2'b10);
      pulseBase();
      chk("R7 rstReq released", rstReq, 0);
      wrReg(2'd2, 8'h00);
    end

    // R10 simultaneous trips: channel 0 width wins
    wrReg(2'd0, 8'h0D);
    wrReg(2'd1, 8'hCD);
    tamperIn = 2'b11;
    tick();
    chk("R10 both flags", tamperFlag, 3);
    tamperIn = 2'b00;
    pulseBase();
    chk("R10 channel 0 width", extClr, 0);
    pulseBase();
    chk("R7 rstReq released", rstReq, 0);
    wrReg(2'd2, 8'h00);

    // R10 retrigger while pulse runs does not restart it
    wrReg(2'd0, 8'hCD);
    wrReg(2'd1, 8'h0D);
    tamperIn = 2'b01;
    tick();
    tamperIn = 2'b00;
    pulseBase();
    tamperIn = 2'b10;
    tick();
    chk("R10 late trip flags", tamperFlag, 3);
    tamperIn = 2'b00;
    for (int k = 2; k <= 8; k++) begin
      pulseBase();
      chk("R10 pulse not restarted", extClr, (k < 8) ? 1 : 0);
    end
    wrReg(2'd2, 8'h01);
    chk("R8 mask keeps flag 0", tamperFlag, 1);
    wrReg(2'd2, 8'h00);
    chk("R8 all cleared", tamperFlag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule